// File: doc/BRIEF.md
# Two-Register Stack Function Unit

This block is the execution datapath of a 16-bit stack machine with Forth-like semantics. The top of stack (T) and the entry under it (N) sit in registers. All deeper entries sit in a small circular stack memory behind N. A sequencer drives a 16-bit opcode and an execute strobe, and the block carries out that opcode in one clock. The opcodes cover stack shuffles, arithmetic, bitwise logic, shifts, comparisons and two I/O actions.

A separate strobe pushes an immediate value that the sequencer has fetched. One I/O opcode pushes the 8-bit switch input. The other copies T into a display register. A flag that is high whenever T is zero goes back to the sequencer in every cycle for conditional branching.

An operation that consumes two operands reads N and T, leaves its result in T, and refills N from the stack memory. Comparisons return 0xFFFF for true and 0x0000 for false.

Top module: `tos_datapath`

## Requirements
- R1: After a synchronous active-low reset, T, N, every stack memory entry and the display register are all zero.
- R2: When the execute strobe is low, nothing changes. When the opcode is 0x0000 or any undefined code, nothing changes either. "Nothing" covers T, N, the stack memory and the display.
- R3: Opcode 0x0001 copies T into N and pushes the old N into the stack memory. Opcode 0x0002 exchanges T and N.
- R4: Opcode 0x0010 computes N+T, and opcode 0x0011 computes N-T, both modulo 2^16. Each puts the result in T and pops the stack memory into N.
- R5: These opcodes act on T only, and N and the stack memory are left untouched:
  - 0x0012 adds 1 to T and 0x0013 subtracts 1.
  - 0x0018 shifts T left by one.
  - 0x0019 shifts T right by one and fills with zero.
  - 0x001A shifts T right by one and repeats bit 15.
- R6: Opcode 0x0014 replaces T with its bitwise complement. Opcodes 0x0015, 0x0016 and 0x0017 put N AND T, N OR T and N XOR T in T and pop.
- R7: Opcode 0x001B shifts N right (zero fill) by the count held in T. Opcode 0x001C shifts N left by that count. A count of 16 or more gives zero. Both opcodes put the result in T and pop.
- R8: Opcode 0x0020 pushes 0xFFFF and opcode 0x0021 pushes 0x0000. A push means: the old N goes to the stack memory, the old T goes to N, and the new value goes to T.
- R9: Each comparison writes 0xFFFF for true and 0x0000 for false into T.
  - Two opcodes act on T alone: 0x0022 tests T==0 and 0x0023 tests T<0 as a signed value.
  - The others compare N against T and pop. The unsigned forms are 0x0024 N>T, 0x0025 N<T, 0x0027 N>=T and 0x0028 N<=T.
  - 0x0026 tests N==T and 0x0029 tests N!=T.
  - The signed forms are 0x002A N>T, 0x002B N<T, 0x002C N>=T and 0x002D N<=T.
- R10: Opcode 0x0037 pushes the switch input, zero-extended to 16 bits. Opcode 0x0038 copies T into the display register and leaves the stack unchanged.
- R11: The literal strobe pushes the literal value. When the literal strobe and the execute strobe are high in the same cycle, the literal wins and the opcode is ignored.
- R12: The zero flag is a combinational function of T. It is high exactly when T is zero, in every cycle.
- R13: The stack memory is a last-in first-out buffer of DEPTH entries. Its pointer wraps, so pushing past DEPTH overwrites the oldest entries. Popping past empty re-reads entries in circular order.
- R14: Start with 0x3B in T and run the opcode sequence 0x0018, 0x0001, 0x0018, 0x0018, 0x0010. This multiplies by ten, and T ends at 0x24E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 16 | Opcode to execute |
| exec_i | input | 1 | Execute strobe for op_i |
| lit_i | input | 1 | Literal push strobe |
| lit_val_i | input | 16 | Literal value |
| sw_i | input | 8 | Switch input |
| disp_o | output | 16 | Display register |
| t_zero_o | output | 1 | High when T is zero |

## Verification
The bench targets the following failure modes:
- Operand order in subtraction, shifts and the ordered comparisons. A swapped design would compute T-N, or shift T by N.
- Signed against unsigned comparison at 0x8000 and 0x7FFF. A design that mixed them up would invert the result there.
- Shift counts of 15, 16 and above. A design that truncates the count would give a non-zero result where zero is required.
- The arithmetic halving of negative values, which a wrong design would zero-fill.
- The literal strobe colliding with an execute strobe.
- Wrap of the stack memory after more than DEPTH pushes, where a design with a wrong pointer would surface stale or shifted entries when popped.

// File: rtl/tosdp_pkg.sv
// Shared widths, opcode codes and stack-effect type for the stack datapath.
// Assumes a 16-bit machine word; the opcode map is fixed.
package tosdp_pkg;
    localparam int DW = 16;

    localparam logic [15:0] OP_IDLE  = 16'h0000;
    localparam logic [15:0] OP_DUP   = 16'h0001;
    localparam logic [15:0] OP_SWAP  = 16'h0002;
    localparam logic [15:0] OP_ADD   = 16'h0010;
    localparam logic [15:0] OP_SUB   = 16'h0011;
    localparam logic [15:0] OP_INC   = 16'h0012;
    localparam logic [15:0] OP_DEC   = 16'h0013;
    localparam logic [15:0] OP_NOT   = 16'h0014;
    localparam logic [15:0] OP_AND   = 16'h0015;
    localparam logic [15:0] OP_OR    = 16'h0016;
    localparam logic [15:0] OP_XOR   = 16'h0017;
    localparam logic [15:0] OP_DBL   = 16'h0018;
    localparam logic [15:0] OP_HLFU  = 16'h0019;
    localparam logic [15:0] OP_HLFS  = 16'h001A;
    localparam logic [15:0] OP_SHR   = 16'h001B;
    localparam logic [15:0] OP_SHL   = 16'h001C;
    localparam logic [15:0] OP_TRUE  = 16'h0020;
    localparam logic [15:0] OP_FALSE = 16'h0021;
    localparam logic [15:0] OP_ZEQ   = 16'h0022;
    localparam logic [15:0] OP_ZLT   = 16'h0023;
    localparam logic [15:0] OP_UGT   = 16'h0024;
    localparam logic [15:0] OP_ULT   = 16'h0025;
    localparam logic [15:0] OP_EQ    = 16'h0026;
    localparam logic [15:0] OP_UGE   = 16'h0027;
    localparam logic [15:0] OP_ULE   = 16'h0028;
    localparam logic [15:0] OP_NE    = 16'h0029;
    localparam logic [15:0] OP_SGT   = 16'h002A;
    localparam logic [15:0] OP_SLT   = 16'h002B;
    localparam logic [15:0] OP_SGE   = 16'h002C;
    localparam logic [15:0] OP_SLE   = 16'h002D;
    localparam logic [15:0] OP_SWIN  = 16'h0037;
    localparam logic [15:0] OP_SHOW  = 16'h0038;

    // How an opcode moves the stack.
    typedef enum logic [2:0] {
        EFF_NONE,    // no state change
        EFF_UNARY,   // T <= result
        EFF_BINARY,  // T <= result, N <= popped entry
        EFF_PUSH,    // memory <= N, N <= T, T <= result
        EFF_DUP,     // memory <= N, N <= T
        EFF_SWAP,    // T <-> N
        EFF_SHOW     // display <= T
    } effect_e;
endpackage

// File: rtl/tosdp_alu.sv
// Combinational decoder and function unit: maps an opcode plus T, N and the
// switch input to a result word and a stack effect. Assumes op codes of tosdp_pkg.
module tosdp_alu
    import tosdp_pkg::*;
#(
    parameter int W  = DW,
    parameter int SW = 8
) (
    input  logic [15:0]  op,
    input  logic [W-1:0] t,
    input  logic [W-1:0] n,
    input  logic [SW-1:0] sw,
    output logic [W-1:0] res,
    output effect_e      eff
);
    localparam int CW = $clog2(W);
    localparam logic [W-1:0] LIM = W'(W);

    logic [W-1:0] shr_v, shl_v;
    logic         big_cnt;

    // Variable shifts of N by the count in T, saturating to zero.
    always_comb begin
        big_cnt = (t >= LIM);
        shr_v   = big_cnt ? '0 : (n >> t[CW-1:0]);
        shl_v   = big_cnt ? '0 : (n << t[CW-1:0]);
    end

    // Decode opcode into result and stack effect.
    always_comb begin
        res = '0;
        eff = EFF_NONE;
        unique case (op)
            OP_DUP:   eff = EFF_DUP;
            OP_SWAP:  eff = EFF_SWAP;
            OP_SHOW:  eff = EFF_SHOW;
            OP_ADD:   begin res = n + t;  eff = EFF_BINARY; end
            OP_SUB:   begin res = n - t;  eff = EFF_BINARY; end
            OP_AND:   begin res = n & t;  eff = EFF_BINARY; end
            OP_OR:    begin res = n | t;  eff = EFF_BINARY; end
            OP_XOR:   begin res = n ^ t;  eff = EFF_BINARY; end
            OP_SHR:   begin res = shr_v;  eff = EFF_BINARY; end
            OP_SHL:   begin res = shl_v;  eff = EFF_BINARY; end
            OP_UGT:   begin res = {W{n > t}};   eff = EFF_BINARY; end
            OP_ULT:   begin res = {W{n < t}};   eff = EFF_BINARY; end
            OP_EQ:    begin res = {W{n == t}};  eff = EFF_BINARY; end
            OP_UGE:   begin res = {W{n >= t}};  eff = EFF_BINARY; end
            OP_ULE:   begin res = {W{n <= t}};  eff = EFF_BINARY; end
            OP_NE:    begin res = {W{n != t}};  eff = EFF_BINARY; end
            OP_SGT:   begin res = {W{$signed(n) >  $signed(t)}}; eff = EFF_BINARY; end
            OP_SLT:   begin res = {W{$signed(n) <  $signed(t)}}; eff = EFF_BINARY; end
            OP_SGE:   begin res = {W{$signed(n) >= $signed(t)}}; eff = EFF_BINARY; end
            OP_SLE:   begin res = {W{$signed(n) <= $signed(t)}}; eff = EFF_BINARY; end
            OP_INC:   begin res = t + 1'b1; eff = EFF_UNARY; end
            OP_DEC:   begin res = t - 1'b1; eff = EFF_UNARY; end
            OP_NOT:   begin res = ~t;       eff = EFF_UNARY; end
            OP_DBL:   begin res = t << 1;   eff = EFF_UNARY; end
            OP_HLFU:  begin res = t >> 1;   eff = EFF_UNARY; end
            OP_HLFS:  begin res = W'($signed(t) >>> 1); eff = EFF_UNARY; end
            OP_ZEQ:   begin res = {W{t == '0}};  eff = EFF_UNARY; end
            OP_ZLT:   begin res = {W{t[W-1]}};   eff = EFF_UNARY; end
            OP_TRUE:  begin res = '1; eff = EFF_PUSH; end
            OP_FALSE: begin res = '0; eff = EFF_PUSH; end
            OP_SWIN:  begin res = W'(sw); eff = EFF_PUSH; end
            default:  eff = EFF_NONE;
        endcase
    end
endmodule

// File: rtl/tosdp_stack.sv
// Circular LIFO behind the N register. Push writes at the pointer and advances;
// pop retreats; top is the most recent entry. Assumes DEPTH is a power of two
// and that push and pop are never both high.
module tosdp_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] sp;

    // Pointer update with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (push) sp <= sp + 1'b1;
        else if (pop)  sp <= sp - 1'b1;
    end

    // Entry storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= din;
        end
    end

    // Most recently pushed entry.
    assign top = mem[sp - 1'b1];
endmodule

// File: rtl/tos_datapath.sv
// Stack machine datapath: T and N registers, stack memory, function unit and
// display register. Assumes the sequencer gives one opcode per exec strobe.
module tos_datapath
    import tosdp_pkg::*;
#(
    parameter int W     = DW,
    parameter int SW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   op_i,
    input  logic          exec_i,
    input  logic          lit_i,
    input  logic [W-1:0]  lit_val_i,
    input  logic [SW-1:0] sw_i,
    output logic [W-1:0]  disp_o,
    output logic          t_zero_o
);
    logic [W-1:0] t_q, n_q, res, stk_top;
    effect_e      eff, eff_act;
    logic         push, pop;

    tosdp_alu #(.W(W), .SW(SW)) u_alu (
        .op(op_i), .t(t_q), .n(n_q), .sw(sw_i), .res(res), .eff(eff)
    );

    // Effect actually applied this cycle; literal strobe overrides execute.
    always_comb begin
        if (lit_i)       eff_act = EFF_PUSH;
        else if (exec_i) eff_act = eff;
        else             eff_act = EFF_NONE;
        push = (eff_act == EFF_PUSH) || (eff_act == EFF_DUP);
        pop  = (eff_act == EFF_BINARY);
    end

    tosdp_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(n_q), .top(stk_top)
    );

    // T, N and display register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q    <= '0;
            n_q    <= '0;
            disp_o <= '0;
        end else begin
            unique case (eff_act)
                EFF_UNARY:  t_q <= res;
                EFF_BINARY: begin t_q <= res; n_q <= stk_top; end
                EFF_PUSH:   begin t_q <= lit_i ? lit_val_i : res; n_q <= t_q; end
                EFF_DUP:    n_q <= t_q;
                EFF_SWAP:   begin t_q <= n_q; n_q <= t_q; end
                EFF_SHOW:   disp_o <= t_q;
                default:    ;
            endcase
        end
    end

    // Zero flag for the sequencer.
    assign t_zero_o = (t_q == '0);
endmodule

// File: rtl/tos_datapath_chk.sv
// Protocol checker for tos_datapath, bound to every instance.
module tos_datapath_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [15:0]  op_i,
    input logic         exec_i,
    input logic         lit_i,
    input logic [W-1:0] lit_val_i,
    input logic [W-1:0] t_q,
    input logic [W-1:0] n_q,
    input logic [W-1:0] disp_o,
    input logic         t_zero_o
);
    // R11: literal lands in T and old T moves to N
    a_r11_lit_push: assert property (@(posedge clk) disable iff (!rst_n)
        lit_i |=> (t_q == $past(lit_val_i)) && (n_q == $past(t_q)));

    // R2: idle cycles leave T, N and display unchanged
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit_i && (!exec_i || op_i == 16'h0000)) |=>
            ($stable(t_q) && $stable(n_q) && $stable(disp_o)));

    // R10: display copy takes old T and keeps T
    a_r10_show: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit_i && exec_i && op_i == 16'h0038) |=>
            ((disp_o == $past(t_q)) && $stable(t_q) && $stable(n_q)));

    // R3: swap exchanges T and N
    a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit_i && exec_i && op_i == 16'h0002) |=>
            ((t_q == $past(n_q)) && (n_q == $past(t_q))));

    // R12: pushing a zero literal raises the zero flag
    a_r12_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (lit_i && lit_val_i == '0) |=> t_zero_o);
endmodule

bind tos_datapath tos_datapath_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .exec_i(exec_i), .lit_i(lit_i),
    .lit_val_i(lit_val_i), .t_q(t_q), .n_q(n_q), .disp_o(disp_o),
    .t_zero_o(t_zero_o)
);

// File: tb/tos_datapath_tb_top.sv
`timescale 1ns/1ps
// Bench for tos_datapath: random opcode streams against a reference model,
// with directed corner cases. Observes T through the display opcode.
module tos_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op_i;
    logic        exec_i, lit_i;
    logic [15:0] lit_val_i;
    logic [7:0]  sw_i;
    logic [15:0] disp_o;
    logic        t_zero_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] mT, mN, mD;
    logic [15:0] mMem [8];
    int          mSp;

    tos_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .exec_i(exec_i), .lit_i(lit_i),
        .lit_val_i(lit_val_i), .sw_i(sw_i), .disp_o(disp_o), .t_zero_o(t_zero_o)
    );

    always #2.5 clk = ~clk;

    localparam logic [15:0] OPS [32] = '{
        16'h0000, 16'h0001, 16'h0002, 16'h0010, 16'h0011, 16'h0012, 16'h0013,
        16'h0014, 16'h0015, 16'h0016, 16'h0017, 16'h0018, 16'h0019, 16'h001A,
        16'h001B, 16'h001C, 16'h0020, 16'h0021, 16'h0022, 16'h0023, 16'h0024,
        16'h0025, 16'h0026, 16'h0027, 16'h0028, 16'h0029, 16'h002A, 16'h002B,
        16'h002C, 16'h002D, 16'h0037, 16'h0055 };

    function automatic string tag_of(logic [15:0] op);
        if (op == 16'h0001 || op == 16'h0002) return "R3";
        if (op == 16'h0010 || op == 16'h0011) return "R4";
        if (op inside {16'h0012, 16'h0013, 16'h0018, 16'h0019, 16'h001A}) return "R5";
        if (op inside {16'h0014, 16'h0015, 16'h0016, 16'h0017}) return "R6";
        if (op == 16'h001B || op == 16'h001C) return "R7";
        if (op == 16'h0020 || op == 16'h0021) return "R8";
        if (op >= 16'h0022 && op <= 16'h002D) return "R9";
        if (op == 16'h0037 || op == 16'h0038) return "R10";
        return "R2";
    endfunction

    function automatic void m_push(logic [15:0] v);
        mMem[mSp] = mN;
        mSp = (mSp + 1) % 8;
        mN = mT;
        mT = v;
    endfunction

    function automatic void m_bin(logic [15:0] v);
        mSp = (mSp + 7) % 8;
        mT = v;
        mN = mMem[mSp];
    endfunction

    function automatic logic [15:0] tf(logic c);
        return c ? 16'hFFFF : 16'h0000;
    endfunction

    // Reference model of one cycle.
    function automatic void m_step(logic [15:0] op, logic ex, logic lit, logic [15:0] v);
        logic [15:0] a, b;
        a = mN; b = mT;
        if (lit) begin m_push(v); return; end
        if (!ex) return;
        case (op)
            16'h0001: begin mMem[mSp] = mN; mSp = (mSp + 1) % 8; mN = mT; end
            16'h0002: begin mT = a; mN = b; end
            16'h0010: m_bin(a + b);
            16'h0011: m_bin(a - b);
            16'h0012: mT = b + 16'd1;
            16'h0013: mT = b - 16'd1;
            16'h0014: mT = ~b;
            16'h0015: m_bin(a & b);
            16'h0016: m_bin(a | b);
            16'h0017: m_bin(a ^ b);
            16'h0018: mT = {b[14:0], 1'b0};
            16'h0019: mT = {1'b0, b[15:1]};
            16'h001A: mT = {b[15], b[15:1]};
            16'h001B: m_bin(b > 16'd15 ? 16'h0 : a >> b[3:0]);
            16'h001C: m_bin(b > 16'd15 ? 16'h0 : a << b[3:0]);
            16'h0020: m_push(16'hFFFF);
            16'h0021: m_push(16'h0000);
            16'h0022: mT = tf(b == 0);
            16'h0023: mT = tf(b[15]);
            16'h0024: m_bin(tf(a > b));
            16'h0025: m_bin(tf(a < b));
            16'h0026: m_bin(tf(a == b));
            16'h0027: m_bin(tf(a >= b));
            16'h0028: m_bin(tf(a <= b));
            16'h0029: m_bin(tf(a != b));
            16'h002A: m_bin(tf($signed(a) > $signed(b)));
            16'h002B: m_bin(tf($signed(a) < $signed(b)));
            16'h002C: m_bin(tf($signed(a) >= $signed(b)));
            16'h002D: m_bin(tf($signed(a) <= $signed(b)));
            16'h0037: m_push({8'h00, sw_i});
            16'h0038: mD = mT;
            default: ;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(logic [15:0] op, logic ex, logic lit, logic [15:0] v);
        @(negedge clk);
        op_i = op; exec_i = ex; lit_i = lit; lit_val_i = v;
        @(posedge clk);
        #1;
        m_step(op, ex, lit, v);
        exec_i = 1'b0; lit_i = 1'b0;
        check("R12 zero flag", {15'd0, t_zero_o}, {15'd0, mT == 16'h0});
    endtask

    // Show T on the display and compare; tag names the requirement under test.
    task automatic probe(string tag);
        step(16'h0038, 1'b1, 1'b0, 16'h0);
        check(tag, disp_o, mD);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; exec_i = 1'b0; lit_i = 1'b0; op_i = '0; lit_val_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        mT = 0; mN = 0; mD = 0; mSp = 0;
        for (int i = 0; i < 8; i++) mMem[i] = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        sw_i = 8'hA5;
        do_reset();
        // R1: reset state
        check("R1 disp", disp_o, 16'h0);
        check("R1 zero flag", {15'd0, t_zero_o}, 16'd1);
        step(16'h0002, 1'b1, 1'b0, 0); probe("R1 N after reset");

        // R14: multiply by ten
        step(16'h0, 1'b0, 1'b1, 16'h003B);
        step(16'h0018, 1'b1, 1'b0, 0); step(16'h0001, 1'b1, 1'b0, 0);
        step(16'h0018, 1'b1, 1'b0, 0); step(16'h0018, 1'b1, 1'b0, 0);
        step(16'h0010, 1'b1, 1'b0, 0);
        step(16'h0038, 1'b1, 1'b0, 0);
        check("R14 times ten", disp_o, 16'h024E);

        // R11: literal beats execute
        step(16'h0018, 1'b1, 1'b1, 16'h1234); probe("R11 priority");
        // R2: strobe low, idle and unknown code
        step(16'h0018, 1'b0, 1'b0, 0); probe("R2 exec low");
        step(16'h00FF, 1'b1, 1'b0, 0); probe("R2 undefined");
        step(16'h0002, 1'b1, 1'b0, 0); probe("R2 N kept");

        // R9 signed/unsigned boundary
        step(0, 0, 1, 16'h8000); step(0, 0, 1, 16'h7FFF);
        step(16'h0024, 1'b1, 1'b0, 0); probe("R9 unsigned 8000>7FFF");
        step(0, 0, 1, 16'h8000); step(0, 0, 1, 16'h7FFF);
        step(16'h002A, 1'b1, 1'b0, 0); probe("R9 signed 8000>7FFF");

        // R7 shift count edges
        for (int c = 14; c < 19; c++) begin
            step(0, 0, 1, 16'hF00F); step(0, 0, 1, 16'(c));
            step(16'h001C, 1'b1, 1'b0, 0); probe("R7 left count");
            step(0, 0, 1, 16'hF00F); step(0, 0, 1, 16'(c));
            step(16'h001B, 1'b1, 1'b0, 0); probe("R7 right count");
        end

        // R5 arithmetic halving of a negative value
        step(0, 0, 1, 16'h8003); step(16'h001A, 1'b1, 1'b0, 0); probe("R5 signed half");
        step(16'h0019, 1'b1, 1'b0, 0); probe("R5 unsigned half");

        // R10 switch push
        sw_i = 8'hC3; step(16'h0037, 1'b1, 1'b0, 0); probe("R10 switch");

        // R13 wrap: twelve pushes then pops via add
        for (int i = 0; i < 12; i++) step(0, 0, 1, 16'(i * 7 + 1));
        for (int i = 0; i < 12; i++) begin
            step(16'h0010, 1'b1, 1'b0, 0); probe("R13 wrap pop");
        end

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            int sel;
            logic [15:0] op, v;
            sel = int'($urandom % 32);
            op = OPS[sel];
            if ($urandom % 4 == 0) begin
                v = ($urandom % 2 == 0) ? 16'($urandom % 20) : 16'($urandom);
                step(0, 0, 1, v);
            end
            if ($urandom % 16 == 0) sw_i = 8'($urandom);
            step(op, 1'b1, 1'b0, 0);
            probe(tag_of(op));
        end
        finish_run();
    end
endmodule